// File: doc/BRIEF.md
# SPI EEPROM Transaction Sequencer

This block is an SPI master that runs whole serial-EEPROM transactions on behalf of a simple request port. A client presents one request: a direction bit, a 16-bit start address and a byte count. For a write, the payload bytes then arrive on a separate valid/ready byte stream. For a read, the returned bytes leave on a valid-qualified output stream. The block generates the serial clock from a parameterized divider and owns chip select. The device's hold and write-protect pins are assumed to be tied inactive outside the block.

A write takes three phases. First, a frame carrying only the write-enable instruction. Second, a frame with the write instruction, the address and the data; raising chip select at the end of this frame starts the device's internal programming. Third, a loop of status-read frames that runs until the device reports idle, or until a poll limit is reached. A read takes a single frame: the read instruction and the address, followed by dummy bytes, while the data is captured from the device. Write requests that would run past the end of a page are refused before any bus activity. Page splitting is left to the client.

Top module: `spi_eeprom_seq`

## Requirements
- R1: While reset is held and after it is released, chip select is high, the serial clock is low, `busy` and `done` are low, and `req_ready` is high.
- R2: An accepted write first sends a frame made of the single byte 0x06, then raises chip select. The next frame sends 0x02, the address high byte, the address low byte, and then the payload bytes in the order they were accepted on the write stream. A payload byte is taken only on a cycle where `wdata_valid` and `wdata_ready` are both high, and the bus waits with the clock low while no byte is offered.
- R3: After the write frame, the block sends two-byte status frames (0x05 followed by one dummy byte). It repeats them while bit 0 of the returned status byte is 1 and ends the transaction after the first status frame in which that bit is 0.
- R4: An accepted read sends 0x03, the address high byte and the address low byte, then one dummy byte per requested byte, all in one frame. Each byte received during a dummy byte is presented on `rdata` with a one-cycle `rdata_valid`, in order.
- R5: The bus runs in SPI mode 0. The clock idles low and is low whenever chip select is high. MOSI changes only while the clock is low, and MISO is sampled on the rising clock edge. Each byte is sent and received most significant bit first.
- R6: Chip select stays high for at least CS_GAP system clocks between any two frames.
- R7: `busy` rises on the cycle after a request is accepted (`req_valid` and `req_ready` high) and stays high up to and including the single cycle in which `done` is high. `req_ready` is high only while `busy` is low.
- R8: A request with a byte count of 0, or a count above MAX_LEN, is refused. A write whose page offset (address modulo PAGE_BYTES) plus its byte count exceeds PAGE_BYTES is also refused. A write ending exactly on the last byte of a page is accepted. A refused request ends with `done` and `err_page` set and without chip select ever going low.
- R9: If POLL_MAX status frames in a row all return bit 0 set, the block ends the transaction with `err_timeout` set and sends no further status frame.
- R10: `err_page` and `err_timeout` are valid from the `done` cycle. They hold their value until the next request is accepted, and accepting a request clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write transaction, 0 = read transaction |
| req_addr | input | 16 | Start address in the device |
| req_len | input | LEN_W | Number of data bytes |
| wdata_valid | input | 1 | Write payload byte offered |
| wdata_ready | output | 1 | Write payload byte taken this cycle if offered |
| wdata | input | 8 | Write payload byte |
| rdata_valid | output | 1 | One-cycle strobe for a received byte |
| rdata | output | 8 | Received read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err_page | output | 1 | Request refused |
| err_timeout | output | 1 | Device stayed busy through the poll limit |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The embedded properties watch the timing rules on every cycle: the clock stays quiet under a high chip select, MOSI is stable while the clock is high, the chip-select high time meets its minimum, `busy` and `done` keep their bracket, and a refused request never touches the bus. The ordering of frames is left to the bench's scenarios, which use a behavioural device model: the enable frame preceding the write frame, the byte order inside each frame, the number of status polls before completion, the timeout count, page-boundary acceptance and refusal, and the read data itself.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [7:0] OPC_WEN   = 8'h06;
   localparam logic [7:0] OPC_PROG  = 8'h02;
   localparam logic [7:0] OPC_STAT  = 8'h05;
   localparam logic [7:0] OPC_FETCH = 8'h03;

   typedef enum logic [1:0] {
      FR_ENABLE,
      FR_PROG,
      FR_POLL,
      FR_FETCH
   } frame_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_LOAD,
      ST_SHIFT,
      ST_CLOSE,
      ST_GAP,
      ST_FIN
   } seq_state_e;

   function automatic logic [7:0] frame_opcode(input frame_e fr);
      case (fr)
         FR_ENABLE: frame_opcode = OPC_WEN;
         FR_PROG:   frame_opcode = OPC_PROG;
         FR_POLL:   frame_opcode = OPC_STAT;
         default:   frame_opcode = OPC_FETCH;
      endcase
   endfunction
endpackage

// File: rtl/eeseq_req_check.sv
module eeseq_req_check #(
   parameter int PAGE_BYTES = 64,
   parameter int MAX_LEN    = 64,
   parameter int LEN_W      = 7,
   localparam int PW        = $clog2(PAGE_BYTES),
   localparam int SW        = ((LEN_W > PW) ? LEN_W : PW) + 1
) (
   input  logic             is_write,
   input  logic [PW-1:0]    page_off,
   input  logic [LEN_W-1:0] len,
   output logic             ok
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [SW-1:0] end_pos;
   logic          len_ok;
   logic          fits_page;

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (MAX_LEN < 1 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("MAX_LEN must be at least 1 and fit in LEN_W bits");
   end

   always_comb begin
      end_pos   = SW'(page_off) + SW'(len);
      len_ok    = (len != '0) && (len <= LEN_W'(MAX_LEN));
      fits_page = (end_pos <= SW'(PAGE_BYTES));
      ok        = len_ok && (!is_write || fits_page);
   end

   always_comb begin
      if (ok && is_write) assert (32'(page_off) + 32'(len) <= PAGE_BYTES)
         else $error("p_page_fit_r8: write accepted across a page");
   end
endmodule

// File: rtl/eeseq_shift.sv
module eeseq_shift #(
   parameter int SCK_HALF = 2,
   localparam int CW      = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic [7:0] rx_byte,
   output logic       byte_done
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [7:0] sh_q;
   logic [7:0] rx_q;
   logic [2:0] bit_q;
   logic       run_q;
   logic       sck_q;
   logic       done_q;
   logic       tick;

   if (SCK_HALF < 1) begin : g_bad_half
      $error("SCK_HALF must be at least 1");
   end

   if (SCK_HALF == 1) begin : g_div_none
      assign tick = run_q;
   end else begin : g_div_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cnt_q <= '0;
         else if (!run_q || start)                 cnt_q <= '0;
         else if (cnt_q == CW'(SCK_HALF - 1))      cnt_q <= '0;
         else                                      cnt_q <= cnt_q + CW'(1);
      end
      assign tick = run_q && (cnt_q == CW'(SCK_HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            sh_q  <= tx_byte;
            bit_q <= '0;
            run_q <= 1'b1;
            sck_q <= 1'b0;
         end else if (tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               rx_q  <= {rx_q[6:0], miso};
            end else begin
               sck_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  sh_q  <= {sh_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck       = sck_q;
   assign mosi      = sh_q[7];
   assign rx_byte   = rx_q;
   assign byte_done = done_q;

   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));
   p_start_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run_q);
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
   import eeseq_pkg::*;
#(
   parameter int SCK_HALF   = 2,
   parameter int CS_GAP     = 4,
   parameter int POLL_MAX   = 16,
   parameter int PAGE_BYTES = 64,
   parameter int MAX_LEN    = 64,
   localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [15:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             wdata_valid,
   output logic             wdata_ready,
   input  logic [7:0]       wdata,
   output logic             rdata_valid,
   output logic [7:0]       rdata,
   output logic             busy,
   output logic             done,
   output logic             err_page,
   output logic             err_timeout,
   output logic             spi_sck,
   output logic             spi_cs_n,
   output logic             spi_mosi,
   input  logic             spi_miso
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int PW     = $clog2(PAGE_BYTES);
   localparam int IDX_W  = $clog2(MAX_LEN + 4);
   localparam int GAP_W  = $clog2(CS_GAP + 1);
   localparam int POLL_W = $clog2(POLL_MAX + 1);

   if (CS_GAP < 1)   begin : g_bad_gap  $error("CS_GAP must be at least 1");   end
   if (POLL_MAX < 1) begin : g_bad_poll $error("POLL_MAX must be at least 1"); end

   seq_state_e       st_q;
   frame_e           fr_q;
   logic [15:0]      addr_q;
   logic [LEN_W-1:0] len_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] frame_bytes;
   logic [GAP_W-1:0] gap_q;
   logic [POLL_W-1:0] poll_q;
   logic             wip_q;
   logic             cs_q;
   logic             rvalid_q;
   logic [7:0]       rdata_q;
   logic             epage_q;
   logic             eto_q;

   logic             req_ok;
   logic             payload_wr;
   logic [7:0]       hdr_byte;
   logic [7:0]       tx_byte;
   logic             sh_start;
   logic [7:0]       rx_byte;
   logic             byte_done;
   logic             last_byte;

   eeseq_req_check #(
      .PAGE_BYTES(PAGE_BYTES),
      .MAX_LEN   (MAX_LEN),
      .LEN_W     (LEN_W)
   ) u_check (
      .is_write(req_write),
      .page_off(req_addr[PW-1:0]),
      .len     (req_len),
      .ok      (req_ok)
   );

   eeseq_shift #(
      .SCK_HALF(SCK_HALF)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .tx_byte  (tx_byte),
      .miso     (spi_miso),
      .sck      (spi_sck),
      .mosi     (spi_mosi),
      .rx_byte  (rx_byte),
      .byte_done(byte_done)
   );

   always_comb begin
      case (fr_q)
         FR_ENABLE: frame_bytes = IDX_W'(1);
         FR_POLL:   frame_bytes = IDX_W'(2);
         default:   frame_bytes = IDX_W'(3) + IDX_W'(len_q);
      endcase
      case (idx_q)
         IDX_W'(0): hdr_byte = frame_opcode(fr_q);
         IDX_W'(1): hdr_byte = (fr_q == FR_POLL) ? 8'h00 : addr_q[15:8];
         IDX_W'(2): hdr_byte = addr_q[7:0];
         default:   hdr_byte = 8'h00;
      endcase
      payload_wr  = (fr_q == FR_PROG) && (idx_q >= IDX_W'(3));
      tx_byte     = payload_wr ? wdata : hdr_byte;
      wdata_ready = (st_q == ST_LOAD) && payload_wr;
      sh_start    = (st_q == ST_LOAD) && (!payload_wr || wdata_valid);
      last_byte   = (idx_q == frame_bytes - IDX_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         fr_q     <= FR_ENABLE;
         addr_q   <= '0;
         len_q    <= '0;
         idx_q    <= '0;
         gap_q    <= '0;
         poll_q   <= '0;
         wip_q    <= 1'b0;
         cs_q     <= 1'b1;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
         epage_q  <= 1'b0;
         eto_q    <= 1'b0;
      end else begin
         rvalid_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               len_q   <= req_len;
               epage_q <= !req_ok;
               eto_q   <= 1'b0;
               fr_q    <= req_write ? FR_ENABLE : FR_FETCH;
               st_q    <= req_ok ? ST_OPEN : ST_FIN;
            end
            ST_OPEN: begin
               cs_q  <= 1'b0;
               idx_q <= '0;
               st_q  <= ST_LOAD;
            end
            ST_LOAD: if (sh_start) st_q <= ST_SHIFT;
            ST_SHIFT: if (byte_done) begin
               if (fr_q == FR_FETCH && idx_q >= IDX_W'(3)) begin
                  rvalid_q <= 1'b1;
                  rdata_q  <= rx_byte;
               end
               if (fr_q == FR_POLL && idx_q == IDX_W'(1)) wip_q <= rx_byte[0];
               if (last_byte) st_q <= ST_CLOSE;
               else begin
                  idx_q <= idx_q + IDX_W'(1);
                  st_q  <= ST_LOAD;
               end
            end
            ST_CLOSE: begin
               cs_q  <= 1'b1;
               gap_q <= '0;
               st_q  <= ST_GAP;
            end
            ST_GAP: if (gap_q != GAP_W'(CS_GAP - 1)) begin
               gap_q <= gap_q + GAP_W'(1);
            end else begin
               case (fr_q)
                  FR_ENABLE: begin
                     fr_q <= FR_PROG;
                     st_q <= ST_OPEN;
                  end
                  FR_PROG: begin
                     fr_q   <= FR_POLL;
                     poll_q <= '0;
                     st_q   <= ST_OPEN;
                  end
                  FR_POLL: begin
                     if (!wip_q) st_q <= ST_FIN;
                     else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
                        eto_q <= 1'b1;
                        st_q  <= ST_FIN;
                     end else begin
                        poll_q <= poll_q + POLL_W'(1);
                        st_q   <= ST_OPEN;
                     end
                  end
                  default: st_q <= ST_FIN;
               endcase
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (st_q == ST_IDLE);
   assign busy        = (st_q != ST_IDLE);
   assign done        = (st_q == ST_FIN);
   assign spi_cs_n    = cs_q;
   assign rdata_valid = rvalid_q;
   assign rdata       = rdata_q;
   assign err_page    = epage_q;
   assign err_timeout = eto_q;

   logic [GAP_W-1:0] hi_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           hi_cnt_q <= GAP_W'(CS_GAP);
      else if (!spi_cs_n)                   hi_cnt_q <= '0;
      else if (hi_cnt_q != GAP_W'(CS_GAP))  hi_cnt_q <= hi_cnt_q + GAP_W'(1);
   end

   p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt_q >= GAP_W'(CS_GAP)));
   p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));
   p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_page) |-> (spi_cs_n && $past(spi_cs_n)));
   p_rdata_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> (busy && !done));
endmodule

// File: tb/sim_spi_eeprom_seq.sv
module sim_spi_eeprom_seq;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SCK_HALF   = 2;
   localparam int CS_GAP     = 4;
   localparam int POLL_MAX   = 16;
   localparam int PAGE_BYTES = 64;
   localparam int MAX_LEN    = 64;
   localparam int LEN_W      = $clog2(MAX_LEN + 1);
   localparam int BUSY_N     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             req_valid, req_ready, req_write;
   logic [15:0]      req_addr;
   logic [LEN_W-1:0] req_len;
   logic             wdata_valid, wdata_ready;
   logic [7:0]       wdata;
   logic             rdata_valid;
   logic [7:0]       rdata;
   logic             busy, done, err_page, err_timeout;
   logic             spi_sck, spi_cs_n, spi_mosi;
   logic             spi_miso;

   spi_eeprom_seq #(
      .SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX),
      .PAGE_BYTES(PAGE_BYTES), .MAX_LEN(MAX_LEN)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len),
      .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
      .rdata_valid(rdata_valid), .rdata(rdata),
      .busy(busy), .done(done), .err_page(err_page), .err_timeout(err_timeout),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int checks = 0;
   int fails  = 0;
   bit stuck  = 1'b0;

   // device model and bus monitors, all evaluated between clock edges
   logic [7:0]  mem [0:1023];
   bit          wel;
   int          busy_left;
   bit          f_open;
   int          m_bit, m_byte;
   logic [7:0]  m_in, m_op, m_next, m_sh;
   logic [15:0] m_addr, m_ptr;
   int          nfrm;
   logic [7:0]  f_op   [0:255];
   int          f_nb   [0:255];
   logic [15:0] f_addr [0:255];
   int          rd_n;
   logic [7:0]  rd_buf [0:255];
   logic        sck_p, cs_p, mosi_p, done_p, busy_p;
   int          hi_run, min_gap, mode_viol, pulse_viol, part_bytes;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
         wel = 0; busy_left = 0; f_open = 0; m_bit = 0; m_byte = 0;
         m_in = 0; m_op = 0; m_next = 0; m_sh = 0; m_addr = 0; m_ptr = 0;
         nfrm = 0; rd_n = 0; spi_miso = 1'b0;
         sck_p = 0; cs_p = 1; mosi_p = 0; done_p = 0; busy_p = 0;
         hi_run = 1000; min_gap = 1000; mode_viol = 0; pulse_viol = 0; part_bytes = 0;
      end else begin
         if (!stuck && busy_left > BUSY_N) busy_left = 0;
         if (cs_p && !spi_cs_n) begin
            f_open = 1; m_bit = 0; m_byte = 0; m_op = 0; m_next = 0;
            if (hi_run < min_gap) min_gap = hi_run;
         end
         if (!spi_cs_n && spi_sck && !sck_p) begin
            m_in = {m_in[6:0], spi_mosi};
            m_bit++;
            if (m_bit == 8) begin
               m_bit  = 0;
               m_next = 8'h00;
               case (m_byte)
                  0: begin
                     m_op = m_in;
                     if (m_in == 8'h05) m_next = {6'b0, wel, (busy_left != 0)};
                  end
                  1: m_addr[15:8] = m_in;
                  2: begin
                     m_addr[7:0] = m_in;
                     m_ptr = m_addr;
                     if (m_op == 8'h03) begin m_next = mem[m_ptr[9:0]]; m_ptr++; end
                  end
                  default: begin
                     if (m_op == 8'h02 && wel)
                        mem[{m_addr[9:6], 6'(m_addr[5:0] + 6'(m_byte - 3))}] = m_in;
                     else if (m_op == 8'h03) begin m_next = mem[m_ptr[9:0]]; m_ptr++; end
                  end
               endcase
               m_byte++;
            end
         end
         if (!spi_cs_n && !spi_sck && sck_p) begin
            if (m_bit == 0) m_sh = m_next;
            spi_miso = m_sh[7];
            m_sh = {m_sh[6:0], 1'b0};
         end
         if (!cs_p && spi_cs_n && f_open) begin
            f_open = 0;
            if (m_bit != 0) part_bytes++;
            if (nfrm < 256) begin
               f_op[nfrm] = m_op; f_nb[nfrm] = m_byte; f_addr[nfrm] = m_addr;
            end
            nfrm++;
            if (m_op == 8'h06 && m_byte == 1) wel = 1;
            else if (m_op == 8'h02 && wel && m_byte >= 4) begin
               busy_left = stuck ? 100000 : BUSY_N;
               wel = 0;
            end else if (m_op == 8'h05 && busy_left > 0 && !stuck) busy_left--;
         end
         if (spi_cs_n) hi_run++; else hi_run = 0;
         if (spi_sck && spi_mosi != mosi_p) mode_viol++;
         if (spi_cs_n && spi_sck) mode_viol++;
         if (done && done_p) pulse_viol++;
         if (busy_p && !busy && !done_p) pulse_viol++;
         if (rdata_valid && rd_n < 256) begin rd_buf[rd_n] = rdata; rd_n++; end
         sck_p = spi_sck; cs_p = spi_cs_n; mosi_p = spi_mosi;
         done_p = done; busy_p = busy;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic d_page, d_to, d_busy;

   task automatic wait_done();
      while (!done) @(negedge clk);
      d_page = err_page; d_to = err_timeout; d_busy = busy;
      @(negedge clk);
   endtask

   task automatic issue(input bit wr, input logic [15:0] a, input int n);
      @(negedge clk);
      chk(req_ready == 1'b1, "R7", "req_ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_len = LEN_W'(n);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R7", "busy after acceptance", busy, 1);
   endtask

   task automatic feed(input int n, input logic [7:0] base, input bit stall);
      bit seen;
      for (int i = 0; i < n; i++) begin
         if (stall) repeat (3) @(negedge clk);
         wdata_valid = 1'b1;
         wdata = base + 8'(i);
         do begin
            seen = wdata_ready;
            @(negedge clk);
         end while (!seen);
         wdata_valid = 1'b0;
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1 && spi_sck == 0, "R1", "bus idle in reset", {spi_cs_n, spi_sck}, 2'b10);
      chk(busy == 0 && done == 0 && req_ready == 1, "R1", "status in reset",
          {busy, done, req_ready}, 3'b001);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(spi_cs_n == 1 && busy == 0 && req_ready == 1, "R1", "idle after reset",
          {spi_cs_n, busy, req_ready}, 3'b101);
   endtask

   task automatic t_write(input logic [15:0] a, input int n, input logic [7:0] base,
                          input bit stall, input string tag);
      int s = nfrm;
      issue(1'b1, a, n);
      fork
         feed(n, base, stall);
         wait_done();
      join
      chk(d_busy == 1 && d_page == 0 && d_to == 0, "R7", {tag, " done with busy, no error"},
          {d_busy, d_page, d_to}, 3'b100);
      chk(nfrm - s == 2 + BUSY_N + 1, "R3", {tag, " frame count"}, nfrm - s, 2 + BUSY_N + 1);
      chk(f_op[s] == 8'h06 && f_nb[s] == 1, "R2", {tag, " enable frame"}, {f_op[s], 8'(f_nb[s])},
          {8'h06, 8'd1});
      chk(f_op[s+1] == 8'h02 && f_nb[s+1] == 3 + n && f_addr[s+1] == a, "R2",
          {tag, " write frame header"}, {f_op[s+1], f_addr[s+1]}, {8'h02, a});
      for (int k = 0; k < BUSY_N + 1; k++)
         chk(f_op[s+2+k] == 8'h05 && f_nb[s+2+k] == 2, "R3", {tag, " status frame"},
             {f_op[s+2+k], 8'(f_nb[s+2+k])}, {8'h05, 8'd2});
      for (int i = 0; i < n; i++)
         chk(mem[10'(a + 16'(i))] == base + 8'(i), "R2", {tag, " stored byte"},
             mem[10'(a + 16'(i))], base + 8'(i));
   endtask

   task automatic t_read(input logic [15:0] a, input int n, input logic [7:0] exp [],
                         input string tag);
      int s = nfrm;
      int r = rd_n;
      issue(1'b0, a, n);
      wait_done();
      chk(d_page == 0 && d_to == 0, "R10", {tag, " flags clear"}, {d_page, d_to}, 0);
      chk(nfrm - s == 1 && f_op[s] == 8'h03 && f_nb[s] == 3 + n && f_addr[s] == a, "R4",
          {tag, " read frame"}, {f_op[s], f_addr[s]}, {8'h03, a});
      chk(rd_n - r == n, "R4", {tag, " byte count"}, rd_n - r, n);
      for (int i = 0; i < n; i++)
         chk(rd_buf[r+i] == exp[i], "R4", {tag, " data byte"}, rd_buf[r+i], exp[i]);
   endtask

   task automatic t_reject(input bit wr, input logic [15:0] a, input int n, input string tag);
      int s = nfrm;
      issue(wr, a, n);
      wait_done();
      chk(d_page == 1, "R8", {tag, " err_page"}, d_page, 1);
      chk(nfrm == s && spi_cs_n == 1, "R8", {tag, " no frame"}, nfrm - s, 0);
      chk(err_page == 1, "R10", {tag, " err_page held"}, err_page, 1);
   endtask

   task automatic t_timeout();
      int s = nfrm;
      stuck = 1'b1;
      issue(1'b1, 16'h0010, 1);
      fork
         feed(1, 8'hC3, 1'b0);
         wait_done();
      join
      chk(d_to == 1 && d_page == 0, "R9", "timeout flag", {d_to, d_page}, 2'b10);
      chk(nfrm - s == 2 + POLL_MAX, "R9", "status frames before timeout", nfrm - s - 2, POLL_MAX);
      repeat (40) @(negedge clk);
      chk(nfrm - s == 2 + POLL_MAX && err_timeout == 1, "R9", "no polling after timeout",
          nfrm - s - 2, POLL_MAX);
      stuck = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [7:0] e1 [];
      logic [7:0] e2 [];
      req_valid = 0; req_write = 0; req_addr = 0; req_len = 0;
      wdata_valid = 0; wdata = 0;
      t_reset();
      t_write(16'h0123, 5, 8'hA0, 1'b1, "write stalled");
      t_write(16'h02FC, 4, 8'h50, 1'b0, "write at page end");
      e1 = new[5];
      for (int i = 0; i < 5; i++) e1[i] = 8'hA0 + 8'(i);
      t_read(16'h0123, 5, e1, "read back");
      e2 = new[6];
      for (int i = 0; i < 4; i++) e2[i] = 8'h50 + 8'(i);
      e2[4] = 8'(16'h300 * 7 + 3);
      e2[5] = 8'(16'h301 * 7 + 3);
      t_read(16'h02FC, 6, e2, "read across page");
      t_reject(1'b1, 16'h02FD, 4, "write over page end");
      t_reject(1'b0, 16'h0040, 0, "zero length read");
      t_timeout();
      e1 = new[1];
      e1[0] = 8'hC3;
      t_read(16'h0010, 1, e1, "read after timeout");
      chk(mode_viol == 0, "R5", "mosi moved with sck high or sck under idle cs", mode_viol, 0);
      chk(part_bytes == 0, "R5", "frames with partial bytes", part_bytes, 0);
      chk(min_gap >= CS_GAP, "R6", "minimum chip-select high time", min_gap, CS_GAP);
      chk(pulse_viol == 0, "R7", "busy/done bracket", pulse_viol, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R7 run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule